// File: doc/BRIEF.md
# Clock Divider and Power-Mode Controller

This block produces the system clock enable for a core from its oscillator clock. Software picks how many oscillator cycles make up one system clock: 1, 2, 4 or 8 through a two-bit divide field, or 256 when the power-saving mode is enabled. The output is a one-cycle strobe in the `clk_i` domain, not a gated clock. A ratio change takes effect only when the current system-clock period ends, so no period is ever cut short.

While the power-saving mode is on, an optional switchback drops the block back to the divide-field rate when any enabled interrupt is raised. External interrupts count as interrupts for this purpose. The fallback lasts until software clears the power-saving enable. A stop request halts the system clock and turns the oscillator enable off. Three things end stop mode:

- an enabled external interrupt;
- expiry of the wake-up timer, when that timer is enabled;
- the asynchronous reset.

After a wake, the core is clocked at once from a slow ring oscillator, whose synchronised ticks arrive on `ring_tick_i`. During this time the high-speed oscillator warms up. The warmup counts `WARM_CYC` oscillator cycles, and only cycles in which the oscillator reports ready are counted. When the count completes, the block returns to the divided high-speed clock. The flops are modelled on `clk_i` throughout; in silicon the wake detection path would be asynchronous.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: With power-saving off, `sys_en_o` pulses once every 2^`div_sel_i` cycles (field 00=1, 01=2, 10=4, 11=8).
- R2: With `pmm_en_i`=1 and no switchback, `sys_en_o` pulses once every 256 cycles and `pmm_o` is 1.
- R3: With `pmm_en_i`=1 and `swb_en_i`=1, any bit set in both `irq_i` and `irq_en_i`, or in both `ext_irq_i` and `ext_en_i`, has two effects. `pmm_o` reads 0 after the next clock edge. The period returns to the divide-field rate until `pmm_en_i` falls.
- R4: An interrupt whose enable bit is 0 does not cause switchback.
- R5: A change of ratio applies only at the end of the current period: the period in progress keeps its old length.
- R6: A one-cycle `stop_req_i` in run state takes effect at the next clock edge: `stopped_o`=1, `osc_en_o`=0, and `sys_en_o` stays 0 for as long as stop lasts.
- R7: Stop exits to warmup on an enabled external interrupt or on `wkt_exp_i` with `wkt_en_i`=1. Disabled sources leave the block stopped.
- R8: During warmup, `src_ring_o`=1, `warming_o`=1 and `sys_en_o` equals `ring_tick_i`.
- R9: Warmup lasts `WARM_CYC` clock cycles in which `osc_rdy_i`=1. Cycles with `osc_rdy_i`=0 do not count. After warmup the block runs from the high-speed clock at the selected rate.
- R10: A `stop_req_i` while a wake source is already pending leaves the block running.
- R11: Asserting `rst_ni` low ends stop mode at once: `stopped_o`=0 and `osc_en_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-speed oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_sel_i | input | 2 | Divide field, ratio 2^value |
| pmm_en_i | input | 1 | Divide-by-256 power-saving enable |
| swb_en_i | input | 1 | Switchback enable |
| irq_i | input | N_IRQ | Interrupt flags |
| irq_en_i | input | N_IRQ | Interrupt enables |
| ext_irq_i | input | N_EXT | External interrupt flags |
| ext_en_i | input | N_EXT | External interrupt enables |
| wkt_en_i | input | 1 | Wake-up timer enable |
| wkt_exp_i | input | 1 | Wake-up timer expiry |
| stop_req_i | input | 1 | One-cycle stop request |
| ring_tick_i | input | 1 | Synchronised ring oscillator tick |
| osc_rdy_i | input | 1 | High-speed oscillator ready |
| sys_en_o | output | 1 | System clock enable strobe |
| src_ring_o | output | 1 | Clock source is ring oscillator |
| osc_en_o | output | 1 | High-speed oscillator enable |
| stopped_o | output | 1 | Stop mode active |
| warming_o | output | 1 | Warmup in progress |
| pmm_o | output | 1 | Divide-by-256 rate in force |

## Verification
A corrupted divider count or a latched ratio shows up as a wrong interval between `sys_en_o` strobes. The error is visible within one period, so at most 256 cycles. A wrong sequencer state shows up at once on `stopped_o`, `src_ring_o` or `osc_en_o`, in the cycle after the faulty transition. A wrong warmup count moves the fall of `src_ring_o` away from exactly `WARM_CYC` ready cycles. A stuck switchback flag leaves `pmm_o` at the wrong value on the cycle after the interrupt.

// File: rtl/clk_pwr_pkg.sv
package clk_pwr_pkg;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_STOP = 2'd1,
    PS_WARM = 2'd2
  } pwr_state_e;

endpackage

// File: rtl/cpc_mode.sv
module cpc_mode #(
  parameter int N_IRQ     = 4,
  parameter int N_EXT     = 2,
  parameter int PMM_SHIFT = 8,
  parameter int SH_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       div_sel_i,
  input  logic             pmm_en_i,
  input  logic             swb_en_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_EXT-1:0] ext_irq_i,
  input  logic [N_EXT-1:0] ext_en_i,
  output logic             pmm_active_o,
  output logic [SH_W-1:0]  shift_o
);

  logic swb_q;
  logic hit;

  assign hit = (|(irq_i & irq_en_i)) | (|(ext_irq_i & ext_en_i));

  // switchback latch, held until power-saving is disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        swb_q <= 1'b0;
    else if (!pmm_en_i)                 swb_q <= 1'b0;
    else if (swb_en_i && hit)           swb_q <= 1'b1;
  end

  assign pmm_active_o = pmm_en_i & ~swb_q;
  assign shift_o = pmm_active_o ? SH_W'(PMM_SHIFT) : SH_W'(div_sel_i);

  AST_SWB_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmm_en_i && swb_en_i && hit) |=> (!pmm_active_o || !pmm_en_i)) // R3
    else $error("switchback did not leave power-saving rate");

  AST_SWB_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmm_en_i && !swb_en_i && pmm_active_o) |=> (pmm_active_o || !pmm_en_i)) // R4
    else $error("power-saving rate left without switchback");

endmodule

// File: rtl/cpc_div.sv
module cpc_div #(
  parameter int PMM_SHIFT = 8,
  parameter int SH_W      = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [SH_W-1:0] shift_i,
  output logic            tick_o
);

  localparam int CNT_W = PMM_SHIFT;

  logic [CNT_W-1:0] cnt_q;
  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] mask;
  logic             term;

  assign mask = CNT_W'((1 << sh_q) - 1);
  assign term = (cnt_q == mask);

  // ratio reloads only at period end or while held idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (!run_i || term) begin
      cnt_q <= '0;
      sh_q  <= shift_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i & term;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= mask) // R5
    else $error("divider count beyond period");

  AST_RATIO_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !term) |=> $stable(sh_q)) // R5
    else $error("ratio changed mid-period");

endmodule

// File: rtl/cpc_seq.sv
module cpc_seq
  import clk_pwr_pkg::*;
#(
  parameter int WARM_CYC = 65536
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stop_req_i,
  input  logic       wake_i,
  input  logic       osc_rdy_i,
  output pwr_state_e state_o
);

  localparam int WC_W = $clog2(WARM_CYC + 1);
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(WARM_CYC - 1);

  pwr_state_e       state_q;
  logic [WC_W-1:0]  wcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_RUN;
      wcnt_q  <= '0;
    end else begin
      unique case (state_q)
        PS_RUN:  if (stop_req_i && !wake_i) state_q <= PS_STOP;
        PS_STOP: if (wake_i) begin
          state_q <= PS_WARM;
          wcnt_q  <= '0;
        end
        PS_WARM: if (osc_rdy_i) begin
          if (wcnt_q == WC_LAST) state_q <= PS_RUN;
          else                   wcnt_q  <= wcnt_q + 1'b1;
        end
        default: state_q <= PS_RUN;
      endcase
    end
  end

  assign state_o = state_q;

  AST_PENDING_NO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_RUN && stop_req_i && wake_i) |=> (state_q == PS_RUN)) // R10
    else $error("stop entered with wake pending");

  AST_STOP_TO_WARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_STOP && wake_i) |=> (state_q == PS_WARM)) // R7
    else $error("wake did not leave stop");

  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_WARM && !osc_rdy_i) |=> (state_q == PS_WARM && $stable(wcnt_q))) // R9
    else $error("warmup advanced without oscillator ready");

endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
  import clk_pwr_pkg::*;
#(
  parameter int N_IRQ     = 4,
  parameter int N_EXT     = 2,
  parameter int PMM_SHIFT = 8,
  parameter int WARM_CYC  = 65536
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       div_sel_i,
  input  logic             pmm_en_i,
  input  logic             swb_en_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_EXT-1:0] ext_irq_i,
  input  logic [N_EXT-1:0] ext_en_i,
  input  logic             wkt_en_i,
  input  logic             wkt_exp_i,
  input  logic             stop_req_i,
  input  logic             ring_tick_i,
  input  logic             osc_rdy_i,
  output logic             sys_en_o,
  output logic             src_ring_o,
  output logic             osc_en_o,
  output logic             stopped_o,
  output logic             warming_o,
  output logic             pmm_o
);

  localparam int SH_W = $clog2(PMM_SHIFT + 1);

  logic            wake;
  logic [SH_W-1:0] shift;
  logic            div_tick;
  logic            run;
  pwr_state_e      state;

  assign wake = (|(ext_irq_i & ext_en_i)) | (wkt_en_i & wkt_exp_i);

  cpc_mode #(
    .N_IRQ(N_IRQ), .N_EXT(N_EXT), .PMM_SHIFT(PMM_SHIFT), .SH_W(SH_W)
  ) u_mode (
    .clk_i, .rst_ni, .div_sel_i, .pmm_en_i, .swb_en_i,
    .irq_i, .irq_en_i, .ext_irq_i, .ext_en_i,
    .pmm_active_o(pmm_o), .shift_o(shift)
  );

  cpc_seq #(.WARM_CYC(WARM_CYC)) u_seq (
    .clk_i, .rst_ni, .stop_req_i, .wake_i(wake), .osc_rdy_i, .state_o(state)
  );

  assign run = (state == PS_RUN);

  cpc_div #(.PMM_SHIFT(PMM_SHIFT), .SH_W(SH_W)) u_div (
    .clk_i, .rst_ni, .run_i(run), .shift_i(shift), .tick_o(div_tick)
  );

  always_comb begin
    unique case (state)
      PS_RUN:  sys_en_o = div_tick;
      PS_WARM: sys_en_o = ring_tick_i;
      default: sys_en_o = 1'b0;
    endcase
  end

  assign src_ring_o = (state == PS_WARM);
  assign warming_o  = (state == PS_WARM);
  assign stopped_o  = (state == PS_STOP);
  assign osc_en_o   = (state != PS_STOP);

  AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_o |-> (!sys_en_o && !osc_en_o)) // R6
    else $error("activity during stop");

  AST_RING_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ring_o |-> (sys_en_o == ring_tick_i)) // R8
    else $error("enable not from ring tick in warmup");

  AST_STOP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stopped_o && !warming_o && stop_req_i && !wake) |=> stopped_o) // R6
    else $error("stop request not honoured");

endmodule

// File: tb/tb_clk_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_clk_pwr_ctrl;

  localparam int NI = 4;
  localparam int NE = 2;
  localparam int WC = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic pmm_en = 0, swb_en = 0, wkt_en = 0, wkt_exp = 0, stop_req = 0;
  logic ring_tick = 0, osc_rdy = 1;
  logic [NI-1:0] irq = '0, irq_en = '0;
  logic [NE-1:0] ext_irq = '0, ext_en = '0;
  logic sys_en, src_ring, osc_en, stopped, warming, pmm;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  clk_pwr_ctrl #(.N_IRQ(NI), .N_EXT(NE), .PMM_SHIFT(8), .WARM_CYC(WC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .div_sel_i(div_sel), .pmm_en_i(pmm_en),
    .swb_en_i(swb_en), .irq_i(irq), .irq_en_i(irq_en), .ext_irq_i(ext_irq),
    .ext_en_i(ext_en), .wkt_en_i(wkt_en), .wkt_exp_i(wkt_exp),
    .stop_req_i(stop_req), .ring_tick_i(ring_tick), .osc_rdy_i(osc_rdy),
    .sys_en_o(sys_en), .src_ring_o(src_ring), .osc_en_o(osc_en),
    .stopped_o(stopped), .warming_o(warming), .pmm_o(pmm)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic get_period(output int n);
    int k = 0;
    do begin @(negedge clk); k++; end while (!sys_en && k < 1000);
    n = 0;
    do begin @(negedge clk); n++; end while (!sys_en && n < 1000);
  endtask

  task automatic t_reset;
    check("R6 reset stopped", stopped, 0);
    check("R8 reset src_ring", src_ring, 0);
    check("R6 reset osc_en", osc_en, 1);
    check("R2 reset pmm", pmm, 0);
  endtask

  task automatic t_ratios;
    int p;
    for (int d = 0; d < 4; d++) begin
      div_sel = 2'(d);
      get_period(p);
      get_period(p);
      check($sformatf("R1 period div_sel=%0d", d), p, 1 << d);
    end
  endtask

  task automatic t_pmm;
    int p;
    div_sel = 2'd1;
    pmm_en = 1;
    get_period(p);
    get_period(p);
    check("R2 pmm period", p, 256);
    check("R2 pmm status", pmm, 1);
    pmm_en = 0;
    get_period(p);
    get_period(p);
    check("R1 period after pmm off", p, 2);
  endtask

  task automatic t_switchback;
    int p;
    div_sel = 2'd1;
    pmm_en = 1;
    swb_en = 1;
    @(negedge clk);
    irq = 4'b0100; irq_en = 4'b0000;
    @(negedge clk);
    irq = '0;
    check("R4 disabled irq keeps pmm", pmm, 1);
    get_period(p);
    get_period(p);
    check("R4 period stays 256", p, 256);
    swb_en = 0; irq = 4'b0100; irq_en = 4'b0100;
    @(negedge clk);
    irq = '0;
    check("R4 switchback disabled keeps pmm", pmm, 1);
    swb_en = 1; irq = 4'b0100;
    @(negedge clk);
    irq = '0; irq_en = '0;
    check("R3 switchback pmm status", pmm, 0);
    get_period(p);
    get_period(p);
    check("R3 period after switchback", p, 2);
    pmm_en = 0;
    @(negedge clk);
    pmm_en = 1;
    @(negedge clk);
    check("R3 flag cleared by pmm off", pmm, 1);
    ext_irq = 2'b10; ext_en = 2'b10;
    @(negedge clk);
    ext_irq = '0; ext_en = '0;
    check("R3 external switchback", pmm, 0);
    pmm_en = 0; swb_en = 0;
    get_period(p);
  endtask

  task automatic t_boundary;
    int p, n;
    div_sel = 2'd3;
    get_period(p);
    get_period(p);
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 3) div_sel = 2'd0;
    end while (!sys_en && n < 1000);
    check("R5 old period completes", n, 8);
    get_period(p);
    check("R5 new period after boundary", p, 1);
  endtask

  task automatic stop_now;
    @(negedge clk);
    stop_req = 1;
    @(negedge clk);
    stop_req = 0;
  endtask

  task automatic t_stop_ext;
    int cnt = 0, n = 0;
    bit ok = 1;
    div_sel = 2'd0;
    stop_now();
    check("R6 stopped", stopped, 1);
    check("R6 osc off", osc_en, 0);
    for (int i = 0; i < 20; i++) begin @(negedge clk); cnt += int'(sys_en); end
    check("R6 no strobes in stop", cnt, 0);
    ext_irq = 2'b01; ext_en = 2'b10;
    wkt_exp = 1; wkt_en = 0;
    repeat (5) @(negedge clk);
    check("R7 disabled sources keep stop", stopped, 1);
    wkt_exp = 0;
    ext_en = 2'b01;
    @(negedge clk);
    ext_irq = '0; ext_en = '0;
    check("R7 ext wake to warmup", warming, 1);
    check("R8 ring source", src_ring, 1);
    while (warming && n < 1000) begin
      n++;
      ring_tick = n[0];
      #1;
      if (sys_en != ring_tick) ok = 0;
      @(negedge clk);
    end
    ring_tick = 0;
    check("R8 enable follows ring tick", int'(ok), 1);
    check("R9 warmup length", n, WC);
    check("R9 back on high-speed source", src_ring, 0);
    @(negedge clk);
    check("R9 run strobes at rate 1", sys_en, 1);
  endtask

  task automatic t_stop_timer_stall;
    int n = 0;
    stop_now();
    check("R6 stopped again", stopped, 1);
    wkt_en = 1; wkt_exp = 1;
    @(negedge clk);
    wkt_exp = 0; wkt_en = 0;
    check("R7 timer wake", warming, 1);
    while (warming && n < 1000) begin
      n++;
      osc_rdy = !(n >= 3 && n <= 7);
      @(negedge clk);
    end
    osc_rdy = 1;
    check("R9 stalled warmup length", n, WC + 5);
  endtask

  task automatic t_pending;
    ext_irq = 2'b10; ext_en = 2'b10;
    stop_now();
    check("R10 pending wake no stop", stopped, 0);
    check("R10 still strobing", sys_en, 1);
    ext_irq = '0; ext_en = '0;
  endtask

  task automatic t_reset_exit;
    stop_now();
    check("R11 stopped before reset", stopped, 1);
    rst_ni = 0;
    #1;
    check("R11 reset leaves stop", stopped, 0);
    check("R11 osc on after reset", osc_en, 1);
    @(negedge clk);
    rst_ni = 1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_ratios();
    t_pmm();
    t_switchback();
    t_boundary();
    t_stop_ext();
    t_stop_timer_stall();
    t_pending();
    t_reset_exit();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule